// File: doc/BRIEF.md
# UART Receive Line Status Tracker

This block sits between a UART's serial deserializer and its register interface. It stores received characters in a receive queue. Each queue entry holds the character and its own parity, framing and break flags, so the reported error bits always describe the character that software reads next. The block also keeps the 8-bit line status byte, clears its sticky bits when software reads the status, and raises a receiver-line-status interrupt.

The block has two modes, selected by `fifo_en`. With `fifo_en` low it behaves as a single holding register. With `fifo_en` high it is a queue of `DEPTH` entries. Transmit-side emptiness arrives as plain inputs and is only reported.

The character input is a valid-only stream. `chr_valid` is never back-pressured. A character that finds no room is counted as an overrun and is not stored. The read side is a plain strobe, `rbr_rd`, which pops the head entry.

Top module: `uart_rx_line_status`

## Requirements
- R1: After reset, with all three transmit-empty inputs high, `lsr` reads 0x60 and `rls_irq` is low. The `lsr` bit order, from bit 7 down to bit 0, is: error-in-queue, transmitter empty, holding empty, break, framing, parity, overrun, data ready.
- R2: `lsr[0]` (data ready) is 1 exactly when at least one character is stored. It goes high the cycle after a character is stored. It drops after the read that removes the last stored character.
- R3: In queue mode, up to `DEPTH` (default 16) characters are kept in arrival order. `rbr_data` shows the oldest one, or 0 when none is stored. `rbr_rd` removes it.
- R4: In queue mode, a character arriving while `DEPTH` entries are stored, with no `rbr_rd` in the same cycle, sets `lsr[1]` (overrun) in the next cycle. That character is discarded.
- R5: In single mode, at most one character is held. A character arriving while one is held and not read in the same cycle sets `lsr[1]` and replaces the held character.
- R6: `lsr[2]` (parity), `lsr[3]` (framing) and `lsr[4]` (break) are set in the cycle after a character carrying that flag becomes the head entry. Once set, they stay set until a status read.
- R7: A status read (`lsr_rd`) clears `lsr[4:1]` in the next cycle. If a set event for a bit occurs in the same cycle as the read, that bit stays 1.
- R8: `lsr[7]` (error-in-queue) is 0 whenever `fifo_en` is low. In queue mode it is 1 whenever any stored entry carries a flag. Once every flagged entry has left, it stays 1 until a status read clears it.
- R9: `lsr[5]` equals `txf_empty` in queue mode and `thr_empty` in single mode. `lsr[6]` equals `lsr[5]` AND `tsr_empty`.
- R10: `rls_irq` is high whenever any of `lsr[4:1]` is high.
- R11: In any cycle where `fifo_en` differs from its value in the previous cycle, all stored characters are dropped. An arriving character and `rbr_rd` are ignored in that cycle. The mode register resets to single mode.
- R12: In queue mode, when the queue is full, a character arriving together with `rbr_rd` is stored without an overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | 1 selects queue mode, 0 selects single-register mode |
| chr_valid | input | 1 | One-cycle strobe: a complete character is available |
| chr_data | input | 8 | Received character |
| chr_par_err | input | 1 | Parity error flag of the character |
| chr_frm_err | input | 1 | Missing stop bit flag of the character |
| chr_brk | input | 1 | Break flag: the line stayed low for a whole character time |
| rbr_rd | input | 1 | Receive buffer read strobe, pops the head entry |
| lsr_rd | input | 1 | Line status read strobe |
| thr_empty | input | 1 | Transmit holding register empty |
| txf_empty | input | 1 | Transmit queue completely empty |
| tsr_empty | input | 1 | Transmit shift register empty |
| rbr_data | output | 8 | Head character, 0 when none is stored |
| lsr | output | 8 | Line status byte |
| rls_irq | output | 1 | Receiver line status interrupt |

## Verification
The main function is exercised with several input patterns.

- Single-mode sequences of back-to-back characters, with and without reads in between, separate overwrite-on-overrun from the plain hold-and-read path.
- Queue-mode fills to exactly `DEPTH` followed by one more character, with and without a same-cycle read, separate discarding from acceptance at the full boundary.
- Flagged characters placed deep in the queue and then drained, with status reads interleaved, show that the error bits follow the head entry rather than the arrival time. They also show that error-in-queue holds until a read after the last flagged entry leaves.
- A long pseudo-random mix of characters, flags, reads, status reads and transmit-empty changes, followed by mode switches with stored data, is compared every cycle against a queue-based model.

// File: rtl/uart_lsr_pkg.sv
package uart_lsr_pkg;
  localparam int unsigned CHAR_W = 8;

  localparam int unsigned LSR_DR   = 0;
  localparam int unsigned LSR_OE   = 1;
  localparam int unsigned LSR_PE   = 2;
  localparam int unsigned LSR_FE   = 3;
  localparam int unsigned LSR_BI   = 4;
  localparam int unsigned LSR_THRE = 5;
  localparam int unsigned LSR_TEMT = 6;
  localparam int unsigned LSR_EIF  = 7;

  localparam int unsigned N_STICKY = 4;

  typedef struct packed {
    logic              brk;
    logic              fe;
    logic              pe;
    logic [CHAR_W-1:0] data;
  } rx_entry_t;

  function automatic logic entry_has_err(rx_entry_t e);
    return e.brk | e.fe | e.pe;
  endfunction
endpackage

// File: rtl/lsr_sticky_flag.sv
module lsr_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
  p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);
endmodule

// File: rtl/lsr_err_count.sv
module lsr_err_count #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             any_next_o
);
  logic [CNT_W-1:0] cnt_next;

  always_comb begin
    if (flush_i) cnt_next = '0;
    else         cnt_next = cnt_o + CNT_W'(inc_i) - CNT_W'(dec_i);
  end

  assign any_next_o = (cnt_next != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_o <= '0;
    else        cnt_o <= cnt_next;
  end

  p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !inc_i && !flush_i) |-> (cnt_o != '0));
endmodule

// File: rtl/lsr_rx_fifo.sv
module lsr_rx_fifo
  import uart_lsr_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           flush_i,
  input  logic                           single_i,
  input  logic                           wr_valid_i,
  input  rx_entry_t                      wr_entry_i,
  input  logic                           rd_req_i,
  output rx_entry_t                      head_o,
  output logic [$clog2(DEPTH+1)-1:0]     count_o,
  output logic                           pop_o,
  output logic                           store_o,
  output logic                           overwrite_o,
  output logic                           overrun_o,
  output logic                           head_load_o,
  output rx_entry_t                      head_next_o
);
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  rx_entry_t        mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr, rd_ptr_nx1;
  logic             full;

  function automatic logic [PTR_W-1:0] ptr_inc(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign rd_ptr_nx1  = ptr_inc(rd_ptr);
  assign full        = single_i ? (count_o != '0) : (count_o == CNT_FULL);
  assign pop_o       = !flush_i && rd_req_i && (count_o != '0);
  assign overrun_o   = !flush_i && wr_valid_i && full && !pop_o;
  assign overwrite_o = overrun_o && single_i;
  assign store_o     = !flush_i && wr_valid_i && !overrun_o;
  assign head_o      = mem[rd_ptr];

  always_comb begin
    head_load_o = 1'b0;
    head_next_o = wr_entry_i;
    if (!flush_i) begin
      if (pop_o && count_o > CNT_ONE) begin
        head_load_o = 1'b1;
        head_next_o = mem[rd_ptr_nx1];
      end else if (store_o && (count_o == '0 || pop_o)) begin
        head_load_o = 1'b1;
      end else if (overwrite_o) begin
        head_load_o = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (store_o)          mem[wr_ptr] <= wr_entry_i;
    else if (overwrite_o) mem[rd_ptr] <= wr_entry_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr  <= '0;
      wr_ptr  <= '0;
      count_o <= '0;
    end else if (flush_i) begin
      rd_ptr  <= '0;
      wr_ptr  <= '0;
      count_o <= '0;
    end else begin
      if (pop_o)   rd_ptr <= rd_ptr_nx1;
      if (store_o) wr_ptr <= ptr_inc(wr_ptr);
      count_o <= count_o + CNT_W'(store_o) - CNT_W'(pop_o);
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count_o <= CNT_FULL);
  p_full_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun_o && !single_i) |=> (count_o == CNT_FULL));
  p_single_depth_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (single_i && !flush_i) |-> (count_o <= CNT_ONE));
  p_full_accept_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush_i && !single_i && wr_valid_i && rd_req_i && count_o == CNT_FULL)
      |=> (count_o == CNT_FULL));
endmodule

// File: rtl/uart_rx_line_status.sv
module uart_rx_line_status
  import uart_lsr_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_en,
  input  logic              chr_valid,
  input  logic [CHAR_W-1:0] chr_data,
  input  logic              chr_par_err,
  input  logic              chr_frm_err,
  input  logic              chr_brk,
  input  logic              rbr_rd,
  input  logic              lsr_rd,
  input  logic              thr_empty,
  input  logic              txf_empty,
  input  logic              tsr_empty,
  output logic [CHAR_W-1:0] rbr_data,
  output logic [7:0]        lsr,
  output logic              rls_irq
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic             mode_q, flush;
  rx_entry_t        in_entry, head, head_next;
  logic [CNT_W-1:0] count, err_cnt;
  logic             pop, store, overwrite, overrun, head_load;
  logic             err_inc, err_dec, err_any_next;
  logic             eif_q, thre;
  logic [N_STICKY-1:0] st_set, st_q;

  assign in_entry = '{brk: chr_brk, fe: chr_frm_err, pe: chr_par_err, data: chr_data};
  assign flush    = (fifo_en != mode_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= fifo_en;
  end

  lsr_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush_i     (flush),
    .single_i    (!fifo_en),
    .wr_valid_i  (chr_valid),
    .wr_entry_i  (in_entry),
    .rd_req_i    (rbr_rd),
    .head_o      (head),
    .count_o     (count),
    .pop_o       (pop),
    .store_o     (store),
    .overwrite_o (overwrite),
    .overrun_o   (overrun),
    .head_load_o (head_load),
    .head_next_o (head_next)
  );

  assign err_inc = (store || overwrite) && entry_has_err(in_entry);
  assign err_dec = (pop || overwrite) && entry_has_err(head);

  lsr_err_count #(.CNT_W(CNT_W)) u_errcnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush_i    (flush),
    .inc_i      (err_inc),
    .dec_i      (err_dec),
    .cnt_o      (err_cnt),
    .any_next_o (err_any_next)
  );

  // sticky order: overrun, parity, framing, break (lsr bits 1..4)
  assign st_set[0] = overrun;
  assign st_set[1] = head_load && head_next.pe;
  assign st_set[2] = head_load && head_next.fe;
  assign st_set[3] = head_load && head_next.brk;

  for (genvar gi = 0; gi < N_STICKY; gi++) begin : g_sticky
    lsr_sticky_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (st_set[gi]),
      .clr_i (lsr_rd),
      .q_o   (st_q[gi])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            eif_q <= 1'b0;
    else if (!fifo_en)     eif_q <= 1'b0;
    else if (err_any_next) eif_q <= 1'b1;
    else if (lsr_rd)       eif_q <= 1'b0;
  end

  assign thre     = fifo_en ? txf_empty : thr_empty;
  assign rbr_data = (count != '0) ? head.data : '0;

  always_comb begin
    lsr                  = '0;
    lsr[LSR_DR]          = (count != '0);
    lsr[LSR_BI:LSR_OE]   = st_q;
    lsr[LSR_THRE]        = thre;
    lsr[LSR_TEMT]        = thre & tsr_empty;
    lsr[LSR_EIF]         = eif_q & fifo_en;
  end

  assign rls_irq = |st_q;

  p_dr_after_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    store |=> lsr[LSR_DR]);
  p_overrun_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> lsr[LSR_OE]);
  p_irq_on_oe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lsr[LSR_OE]) |-> rls_irq);
  p_eif_errs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && mode_q && err_cnt != '0) |-> lsr[LSR_EIF]);
  p_flush_empties_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (rbr_data == '0));
endmodule

// File: tb/uart_rx_line_status_tb.sv
module uart_rx_line_status_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fifo_en = 1'b0, chr_valid = 1'b0, chr_par_err = 1'b0;
  logic       chr_frm_err = 1'b0, chr_brk = 1'b0, rbr_rd = 1'b0, lsr_rd = 1'b0;
  logic       thr_empty = 1'b1, txf_empty = 1'b1, tsr_empty = 1'b1;
  logic [7:0] chr_data = '0;
  logic [7:0] rbr_data, lsr;
  logic       rls_irq;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_rx_line_status #(.DEPTH(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .chr_valid(chr_valid),
    .chr_data(chr_data), .chr_par_err(chr_par_err), .chr_frm_err(chr_frm_err),
    .chr_brk(chr_brk), .rbr_rd(rbr_rd), .lsr_rd(lsr_rd), .thr_empty(thr_empty),
    .txf_empty(txf_empty), .tsr_empty(tsr_empty), .rbr_data(rbr_data),
    .lsr(lsr), .rls_irq(rls_irq)
  );

  // behavioural reference model
  typedef struct { logic [7:0] d; bit pe; bit fe; bit bk; int id; } ment_t;
  ment_t q[$];
  int  next_id = 0;
  bit  m_prev_en = 0, m_oe = 0, m_pe = 0, m_fe = 0, m_bi = 0, m_eif = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit thre, temt, irq;
    logic [7:0] exp_rbr;
    thre = fifo_en ? txf_empty : thr_empty;
    temt = thre & tsr_empty;
    irq  = m_oe | m_pe | m_fe | m_bi;
    exp_rbr = (q.size() > 0) ? q[0].d : 8'h00;
    chk(lsr[0] == (q.size() > 0), "R2 data ready", lsr[0], q.size() > 0);
    chk(rbr_data == exp_rbr, "R3 head data", rbr_data, exp_rbr);
    chk(lsr[1] == m_oe, "R4/R5 overrun", lsr[1], m_oe);
    chk(lsr[4:2] == {m_bi, m_fe, m_pe}, "R6/R7 head error bits", lsr[4:2], {m_bi, m_fe, m_pe});
    chk(lsr[7] == (m_eif & fifo_en), "R8 error in queue", lsr[7], m_eif & fifo_en);
    chk(lsr[6:5] == {temt, thre}, "R9 transmit empties", lsr[6:5], {temt, thre});
    chk(rls_irq == irq, "R10 interrupt", rls_irq, irq);
  endtask

  task automatic model_step();
    int  old_id, ec;
    bit  pop, full, ovr, hc;
    ment_t e;
    old_id = (q.size() > 0) ? q[0].id : -1;
    ovr = 0;
    if (fifo_en != m_prev_en) begin      // R11 flush cycle
      q.delete();
      m_prev_en = fifo_en;
    end else begin
      pop  = rbr_rd && q.size() > 0;
      full = q.size() >= (fifo_en ? 16 : 1);
      ovr  = chr_valid && full && !pop;
      if (pop) void'(q.pop_front());
      if (chr_valid) begin
        e.d = chr_data; e.pe = chr_par_err; e.fe = chr_frm_err; e.bk = chr_brk;
        e.id = next_id++;
        if (!ovr) q.push_back(e);
        else if (!fifo_en) q[0] = e;
      end
    end
    hc = (q.size() > 0) && (q[0].id != old_id);
    m_oe = ovr ? 1'b1 : (lsr_rd ? 1'b0 : m_oe);
    m_pe = (hc && q[0].pe) ? 1'b1 : (lsr_rd ? 1'b0 : m_pe);
    m_fe = (hc && q[0].fe) ? 1'b1 : (lsr_rd ? 1'b0 : m_fe);
    m_bi = (hc && q[0].bk) ? 1'b1 : (lsr_rd ? 1'b0 : m_bi);
    ec = 0;
    foreach (q[i]) if (q[i].pe || q[i].fe || q[i].bk) ec++;
    m_eif = !fifo_en ? 1'b0 : (ec > 0 ? 1'b1 : (lsr_rd ? 1'b0 : m_eif));
  endtask

  // one clock: compare at negedge, drive new inputs, advance model
  task automatic cyc(bit v, logic [7:0] d, bit pe, bit fe, bit bk, bit rr, bit lr);
    @(negedge clk);
    compare_all();
    chr_valid = v; chr_data = d; chr_par_err = pe; chr_frm_err = fe; chr_brk = bk;
    rbr_rd = rr; lsr_rd = lr;
    model_step();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 8'h00, 0, 0, 0, 0, 0);
  endtask

  task automatic set_mode(bit en);
    @(negedge clk);
    compare_all();
    fifo_en = en;
    chr_valid = 0; rbr_rd = 0; lsr_rd = 0;
    model_step();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk(lsr == 8'h60, "R1 reset lsr", lsr, 8'h60);
    chk(rls_irq == 1'b0, "R1 reset irq", rls_irq, 0);

    // single mode: store and read (R2)
    cyc(1, 8'hA5, 0, 0, 0, 0, 0);
    idle(2);
    cyc(0, 8'h00, 0, 0, 0, 1, 0);
    idle(1);
    // R5: overwrite on second character
    cyc(1, 8'h11, 0, 0, 0, 0, 0);
    cyc(1, 8'h22, 1, 0, 0, 0, 0);
    idle(2);
    // R7: status read clears, same-cycle event wins
    cyc(1, 8'h33, 0, 1, 0, 0, 1);
    idle(1);
    cyc(0, 8'h00, 0, 0, 0, 0, 1);
    idle(1);
    cyc(1, 8'h44, 0, 0, 1, 1, 0);   // read and new char same cycle
    idle(1);
    cyc(0, 8'h00, 0, 0, 0, 1, 1);
    idle(2);

    // R11: switch to queue mode with a char arriving in the switch cycle ignored
    @(negedge clk); compare_all();
    fifo_en = 1; chr_valid = 1; chr_data = 8'h99; rbr_rd = 0; lsr_rd = 0;
    model_step();
    idle(2);

    // R3/R4: fill 16, flagged entries deep inside
    for (int i = 0; i < 16; i++)
      cyc(1, 8'(8'h40 + i), i == 5, i == 9, i == 12, 0, 0);
    cyc(1, 8'hEE, 0, 0, 0, 0, 0);   // R4 overrun, discarded
    idle(1);
    cyc(1, 8'hDD, 1, 0, 0, 1, 0);   // R12 full + read accepted
    idle(1);
    // R6/R8: drain with status reads interleaved
    for (int i = 0; i < 18; i++) begin
      cyc(0, 8'h00, 0, 0, 0, 1, 0);
      cyc(0, 8'h00, 0, 0, 0, 0, (i % 3) == 0);
    end
    idle(1);
    cyc(0, 8'h00, 0, 0, 0, 0, 1);   // R8 clears once no errored entries
    idle(2);

    // R9: transmit empties
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); compare_all();
      thr_empty = i[0]; txf_empty = i[1]; tsr_empty = i[2];
      fifo_en = (i >= 4);
      chr_valid = 0; rbr_rd = 0; lsr_rd = 0;
      model_step();
    end
    thr_empty = 1; txf_empty = 1; tsr_empty = 1;
    set_mode(1);
    idle(2);

    // pseudo-random mix
    for (int i = 0; i < 3000; i++) begin
      bit v, rr, lr, pe, fe, bk;
      v  = ($urandom_range(0, 1) == 1);
      rr = ($urandom_range(0, 2) == 0);
      lr = ($urandom_range(0, 3) == 0);
      pe = ($urandom_range(0, 9) == 0);
      fe = ($urandom_range(0, 11) == 0);
      bk = ($urandom_range(0, 19) == 0);
      if (i % 500 == 250) set_mode(!fifo_en);   // R11 with stored data
      if ((i % 97) == 3) begin
        thr_empty = $urandom_range(0, 1); txf_empty = $urandom_range(0, 1);
        tsr_empty = $urandom_range(0, 1);
      end
      cyc(v, 8'($urandom_range(0, 255)), pe, fe, bk, rr, lr);
    end
    idle(3);
    finish_run();
  end
endmodule